// File: doc/BRIEF.md
# Board Power-Good and Reset Sequencer

This block watches the main 5V and standby 5V rails, the sleep-state signals from the south bridge and two reset sources, and from them produces the board's power and reset controls. Both rails arrive as pairs of ready-made digital comparator flags: one flag says the rail is above the upper threshold and the other says it is below the lower one. Between the two thresholds the block keeps the last decision, which gives each rail a hysteresis band. All delays are counted in ticks of a slow reference. The tick is made from the clock by a prescaler, so a bench can shorten every timing by parameter.

The block has these outputs:
- A standby-domain reset that is released a fixed time after the standby rail is good.
- Two identical power-good outputs that rise a longer fixed time after the main rail is good and the reset button is released.
- An active-low supply-on request that follows the inverse of the S3 sleep signal after a short filtered delay.
- Two peripheral resets.
- An active-low select for the 3.3V standby source. A firmware gating bit enables this select. The bit passes through while power is good and is captured when the S3 sleep signal falls.

Every asynchronous input goes through a two-flop synchronizer before use.

Top module: `pwr_rst_seq`

## Requirements
- R1: `pwr_ok_a_o` and `pwr_ok_b_o` rise only after the main rail has been judged good and `btn_rst_n_i` has been high for PG_TICKS reference ticks. The earliest rise is (PG_TICKS-1)*TICK_DIV cycles after the upper flag is set, and the latest is PG_TICKS*TICK_DIV+6 cycles after it.
- R2: Whenever `m5_below_i` is high, both power-good outputs are low within 4 clock cycles. If both flags are high, the below flag wins.
- R3: While both `m5_above_i` and `m5_below_i` are low, the main-rail decision holds its last value and the power-good outputs do not change.
- R4: A low on `btn_rst_n_i` drives both power-good outputs low within 4 cycles. After the button is released they wait the full R1 delay again before they rise.
- R5: `sb_rst_n_o` uses its own hysteresis decision on the standby rail flags and is released after RSM_TICKS ticks. It is low within 4 cycles of `sb5_below_i` going high.
- R6: `psu_on_n_o` settles to the inverse of `slp3_n_i` after PSON_TICKS ticks. A level on `slp3_n_i` that lasts less than (PSON_TICKS-1)*TICK_DIV cycles does not reach the output.
- R7: Entering S3 (`slp3_n_i` low and `slp4_n_i` high) with a captured gate of 1 drives `sb3v_sel_n_o` low. It stays low until `slp3_n_i` is high and power-good is high at the same time.
- R8: The gate `sb_gate_i` is copied while power-good is high and is captured on the falling edge of the synchronized `slp3_n_i`. While power-good is low it is held. A captured 0 keeps `sb3v_sel_n_o` high.
- R9: `card_rst_n_o` and `disk_rst_n_o` are low whenever `chip_rst_n_i` is low or power-good is low. They release together at the first reference tick after both conditions clear.
- R10: During reset the outputs take these values: `sb_rst_n_o`=0, both power-good outputs=0, `psu_on_n_o`=1, both peripheral resets=0, `sb3v_sel_n_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m5_above_i | input | 1 | Main 5V rail above the upper threshold |
| m5_below_i | input | 1 | Main 5V rail below the lower threshold |
| sb5_above_i | input | 1 | Standby 5V rail above the upper threshold |
| sb5_below_i | input | 1 | Standby 5V rail below the lower threshold |
| slp3_n_i | input | 1 | S3 sleep signal, low in S3 through S5 |
| slp4_n_i | input | 1 | S4 sleep signal, low in S4 and S5 |
| btn_rst_n_i | input | 1 | Reset button, active low |
| chip_rst_n_i | input | 1 | Chipset reset, active low |
| sb_gate_i | input | 1 | Firmware gate for the standby source select |
| sb_rst_n_o | output | 1 | Standby-domain reset, active low |
| pwr_ok_a_o | output | 1 | Power-good, first copy |
| pwr_ok_b_o | output | 1 | Power-good, second copy |
| psu_on_n_o | output | 1 | Supply-on request, active low |
| card_rst_n_o | output | 1 | Add-in card reset, active low |
| disk_rst_n_o | output | 1 | Disk interface reset, active low |
| sb3v_sel_n_o | output | 1 | 3.3V standby source select, active low |

## Verification
Each rail is tested in four ways:
- A clean rise, checked against an early and a late sampling point. This separates a correct tick count from one that is short or long by a tick.
- A level parked inside the hysteresis band. This shows whether the decision holds or falls back to the upper flag alone.
- A lower-flag drop, which separates a fast drop from a delayed one.
- A button pulse, which shows whether the power-good delay restarts.

The sleep-signal tests use a true level change and also a pulse shorter than the filter, which separates a counted delay from a plain pipeline. The standby-select tests first capture a gate of 1, then change the gate while power-good is low, and then repeat with a gate of 0. This shows whether the gate is copied, captured at the S3 edge, or held.

// File: rtl/pwr_rst_pkg.sv
package pwr_rst_pkg;
  localparam int unsigned SYNC_W = 9;
  localparam int unsigned IX_M5_HI = 0;
  localparam int unsigned IX_M5_LO = 1;
  localparam int unsigned IX_SB_HI = 2;
  localparam int unsigned IX_SB_LO = 3;
  localparam int unsigned IX_SLP3  = 4;
  localparam int unsigned IX_SLP4  = 5;
  localparam int unsigned IX_BTN   = 6;
  localparam int unsigned IX_CHIP  = 7;
  localparam int unsigned IX_GATE  = 8;
  // pulled-up inputs reset high, flags and the gate reset low
  localparam logic [SYNC_W-1:0] SYNC_RST = 9'b0_1111_0000;
endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      stab_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/pwr_rst_tick.sv
module pwr_rst_tick #(
  parameter int unsigned TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tick_q, tick_d;

  always_comb begin
    if (cnt_q == LAST) begin
      cnt_d  = '0;
      tick_d = 1'b1;
    end else begin
      cnt_d  = cnt_q + 1'b1;
      tick_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/pwr_rst_qual.sv
module pwr_rst_qual #(
  parameter int unsigned TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic hi_i,
  input  logic lo_i,
  input  logic en_i,
  output logic ok_o
);
  localparam int unsigned CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS);

  logic          band_q, band_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ok_q, ok_d;
  logic          cond;

  assign cond = band_q & en_i;

  always_comb begin
    band_d = lo_i ? 1'b0 : (hi_i ? 1'b1 : band_q);
    if (!cond)                         cnt_d = '0;
    else if (tick_i && cnt_q != LAST)  cnt_d = cnt_q + 1'b1;
    else                               cnt_d = cnt_q;
    ok_d = cond && (cnt_q == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      band_q <= 1'b0;
      cnt_q  <= '0;
      ok_q   <= 1'b0;
    end else begin
      band_q <= band_d;
      cnt_q  <= cnt_d;
      ok_q   <= ok_d;
    end
  end

  assign ok_o = ok_q;

  // R2 / R5: a lost rail decision or enable clears the output next cycle
  p_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cond |=> !ok_q);
  // R1 / R5: a rise needs a qualified condition in the cycle before
  p_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok_q) |-> $past(cond));
  // R3: rail decision moves only with a flag present
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_i && !lo_i) |=> $stable(band_q));
endmodule

// File: rtl/pwr_rst_seq.sv
module pwr_rst_seq
  import pwr_rst_pkg::*;
#(
  parameter int unsigned TICK_DIV   = 3125,
  parameter int unsigned PG_TICKS   = 17000,
  parameter int unsigned RSM_TICKS  = 2400,
  parameter int unsigned PSON_TICKS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic m5_above_i,
  input  logic m5_below_i,
  input  logic sb5_above_i,
  input  logic sb5_below_i,
  input  logic slp3_n_i,
  input  logic slp4_n_i,
  input  logic btn_rst_n_i,
  input  logic chip_rst_n_i,
  input  logic sb_gate_i,
  output logic sb_rst_n_o,
  output logic pwr_ok_a_o,
  output logic pwr_ok_b_o,
  output logic psu_on_n_o,
  output logic card_rst_n_o,
  output logic disk_rst_n_o,
  output logic sb3v_sel_n_o
);
  localparam int unsigned PCW = $clog2(PSON_TICKS + 1);
  localparam logic [PCW-1:0] PLAST = PCW'(PSON_TICKS - 1);

  logic [SYNC_W-1:0] raw, syn;
  logic tick, pg, rsm_ok;
  logic slp3_s, slp4_s;

  assign raw[IX_M5_HI] = m5_above_i;
  assign raw[IX_M5_LO] = m5_below_i;
  assign raw[IX_SB_HI] = sb5_above_i;
  assign raw[IX_SB_LO] = sb5_below_i;
  assign raw[IX_SLP3]  = slp3_n_i;
  assign raw[IX_SLP4]  = slp4_n_i;
  assign raw[IX_BTN]   = btn_rst_n_i;
  assign raw[IX_CHIP]  = chip_rst_n_i;
  assign raw[IX_GATE]  = sb_gate_i;

  pwr_rst_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(syn));

  pwr_rst_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick));

  pwr_rst_qual #(.TICKS(PG_TICKS)) u_pg (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .hi_i(syn[IX_M5_HI]), .lo_i(syn[IX_M5_LO]), .en_i(syn[IX_BTN]),
    .ok_o(pg));

  pwr_rst_qual #(.TICKS(RSM_TICKS)) u_rsm (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .hi_i(syn[IX_SB_HI]), .lo_i(syn[IX_SB_LO]), .en_i(1'b1),
    .ok_o(rsm_ok));

  assign slp3_s = syn[IX_SLP3];
  assign slp4_s = syn[IX_SLP4];

  // supply request, peripheral release, S3 flag, gate capture
  logic           psu_q, psu_d;
  logic [PCW-1:0] pcnt_q, pcnt_d;
  logic           rel_q, rel_d;
  logic           s3_q, s3_d;
  logic           gate_q, gate_d;
  logic           slp3_d1_q;
  logic           slp3_fall, psu_diff;

  assign slp3_fall = slp3_d1_q & ~slp3_s;
  assign psu_diff  = (psu_q == slp3_s);

  always_comb begin
    psu_d  = psu_q;
    pcnt_d = pcnt_q;
    if (!psu_diff) begin
      pcnt_d = '0;
    end else if (tick) begin
      if (pcnt_q == PLAST) begin
        psu_d  = ~slp3_s;
        pcnt_d = '0;
      end else begin
        pcnt_d = pcnt_q + 1'b1;
      end
    end

    if (!(syn[IX_CHIP] && pg)) rel_d = 1'b0;
    else if (tick)             rel_d = 1'b1;
    else                       rel_d = rel_q;

    if (!slp3_s && slp4_s)     s3_d = 1'b1;
    else if (slp3_s && pg)     s3_d = 1'b0;
    else                       s3_d = s3_q;

    if (pg || slp3_fall)       gate_d = syn[IX_GATE];
    else                       gate_d = gate_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psu_q     <= 1'b1;
      pcnt_q    <= '0;
      rel_q     <= 1'b0;
      s3_q      <= 1'b0;
      gate_q    <= 1'b0;
      slp3_d1_q <= 1'b1;
    end else begin
      psu_q     <= psu_d;
      pcnt_q    <= pcnt_d;
      rel_q     <= rel_d;
      s3_q      <= s3_d;
      gate_q    <= gate_d;
      slp3_d1_q <= slp3_s;
    end
  end

  assign sb_rst_n_o   = rsm_ok;
  assign pwr_ok_a_o   = pg;
  assign pwr_ok_b_o   = pg;
  assign psu_on_n_o   = psu_q;
  assign card_rst_n_o = rel_q;
  assign disk_rst_n_o = rel_q;
  assign sb3v_sel_n_o = ~(s3_q & gate_q);

  // R6: the request flips only from a state that disagreed with the sleep input
  p_pson_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(psu_q) |-> $past(psu_q == slp3_s));
  // R9: a lost power-good clears the peripheral release
  p_periph_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pg |=> !rel_q);
  // R7: the select turns on only after the S3 signal was seen low
  p_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sb3v_sel_n_o) |-> $past(!slp3_s));
  // R8: with power-good low and no S3 edge, the captured gate holds
  p_gate_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pg && !slp3_fall) |=> $stable(gate_q));
endmodule

// File: tb/pwr_rst_seq_tb.sv
module pwr_rst_seq_tb_top;
  localparam int unsigned DIV  = 4;
  localparam int unsigned PGT  = 8;
  localparam int unsigned RSMT = 5;
  localparam int unsigned PST  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m5_hi = 0, m5_lo = 0, sb_hi = 0, sb_lo = 0;
  logic slp3 = 1, slp4 = 1, btn = 1, chip = 1, gate = 0;
  logic sb_rst_n, pg_a, pg_b, psu_n, card_n, disk_n, sel_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  pwr_rst_seq #(.TICK_DIV(DIV), .PG_TICKS(PGT), .RSM_TICKS(RSMT),
                .PSON_TICKS(PST)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .m5_above_i(m5_hi), .m5_below_i(m5_lo),
    .sb5_above_i(sb_hi), .sb5_below_i(sb_lo),
    .slp3_n_i(slp3), .slp4_n_i(slp4),
    .btn_rst_n_i(btn), .chip_rst_n_i(chip), .sb_gate_i(gate),
    .sb_rst_n_o(sb_rst_n), .pwr_ok_a_o(pg_a), .pwr_ok_b_o(pg_b),
    .psu_on_n_o(psu_n), .card_rst_n_o(card_n), .disk_rst_n_o(disk_n),
    .sb3v_sel_n_o(sel_n));

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    wait_n(3);
    chk("R10", "standby reset", sb_rst_n, 1'b0);
    chk("R10", "power-good a", pg_a, 1'b0);
    chk("R10", "power-good b", pg_b, 1'b0);
    chk("R10", "supply request", psu_n, 1'b1);
    chk("R10", "card reset", card_n, 1'b0);
    chk("R10", "disk reset", disk_n, 1'b0);
    chk("R10", "standby select", sel_n, 1'b1);
    rst_n = 1'b1;
    wait_n(30);
  endtask

  task automatic t_standby();
    sb_hi = 1;
    wait_n((RSMT - 1) * DIV);
    chk("R5", "standby reset early", sb_rst_n, 1'b0);
    wait_n(DIV + 6);
    chk("R5", "standby reset released", sb_rst_n, 1'b1);
    sb_hi = 0; wait_n(20);
    chk("R5", "standby reset held in band", sb_rst_n, 1'b1);
    sb_lo = 1; wait_n(6);
    chk("R5", "standby reset on drop", sb_rst_n, 1'b0);
    sb_lo = 0; sb_hi = 1; wait_n(RSMT * DIV + 10);
    chk("R5", "standby reset restored", sb_rst_n, 1'b1);
  endtask

  task automatic t_pson();
    chk("R6", "request on after reset", psu_n, 1'b0);
    slp3 = 0; slp4 = 0;
    wait_n((PST - 1) * DIV);
    chk("R6", "request before delay", psu_n, 1'b0);
    wait_n(DIV + 5);
    chk("R6", "request off after delay", psu_n, 1'b1);
    slp3 = 1; slp4 = 1;
    wait_n(PST * DIV + 5);
    chk("R6", "request on again", psu_n, 1'b0);
    slp3 = 0; wait_n(4); slp3 = 1;
    wait_n(20);
    chk("R6", "short pulse filtered", psu_n, 1'b0);
  endtask

  task automatic t_pg_rise();
    m5_hi = 1;
    wait_n((PGT - 1) * DIV);
    chk("R1", "power-good early", pg_a, 1'b0);
    wait_n(DIV + 6);
    chk("R1", "power-good a risen", pg_a, 1'b1);
    chk("R1", "power-good b risen", pg_b, 1'b1);
  endtask

  task automatic t_band_and_drop();
    m5_hi = 0; m5_lo = 0;
    wait_n(40);
    chk("R3", "power-good held in band", pg_a, 1'b1);
    m5_lo = 1; wait_n(5);
    chk("R2", "power-good a dropped", pg_a, 1'b0);
    chk("R2", "power-good b dropped", pg_b, 1'b0);
    m5_hi = 1; wait_n(10);
    chk("R2", "below flag wins over above", pg_a, 1'b0);
    m5_lo = 0; wait_n(PGT * DIV + 10);
    chk("R1", "power-good restored", pg_a, 1'b1);
  endtask

  task automatic t_button();
    btn = 0; wait_n(5);
    chk("R4", "button forces low", pg_b, 1'b0);
    btn = 1;
    wait_n((PGT - 1) * DIV);
    chk("R4", "delay rerun early", pg_a, 1'b0);
    wait_n(DIV + 6);
    chk("R4", "delay rerun done", pg_a, 1'b1);
  endtask

  task automatic t_periph();
    chk("R9", "card released with power", card_n, 1'b1);
    chip = 0; wait_n(4);
    chk("R9", "card reset by chipset", card_n, 1'b0);
    chk("R9", "disk reset by chipset", disk_n, 1'b0);
    chip = 1; wait_n(1);
    chk("R9", "card held right after release", card_n, 1'b0);
    wait_n(DIV + 4);
    chk("R9", "card released", card_n, 1'b1);
    chk("R9", "disk released", disk_n, 1'b1);
    m5_hi = 0; m5_lo = 1; wait_n(6);
    chk("R9", "card reset by power-good", card_n, 1'b0);
    m5_lo = 0; m5_hi = 1; wait_n(PGT * DIV + DIV + 12);
    chk("R9", "card released after power-good", disk_n, 1'b1);
  endtask

  task automatic t_select();
    gate = 1; wait_n(6);
    chk("R7", "select off in S0", sel_n, 1'b1);
    slp3 = 0; wait_n(5);
    chk("R7", "select on in S3", sel_n, 1'b0);
    m5_hi = 0; m5_lo = 1; wait_n(6);
    gate = 0; wait_n(6);
    chk("R8", "gate held while power low", sel_n, 1'b0);
    slp3 = 1; wait_n(6);
    chk("R7", "select held until power-good", sel_n, 1'b0);
    m5_lo = 0; m5_hi = 1; wait_n(PGT * DIV + 10);
    chk("R7", "select off in S0 with power", sel_n, 1'b1);
    slp3 = 0; wait_n(8);
    chk("R8", "captured low gate blocks select", sel_n, 1'b1);
    slp3 = 1; wait_n(8);
  endtask

  initial begin
    t_reset();
    t_standby();
    t_pson();
    t_pg_rise();
    t_band_and_drop();
    t_button();
    t_periph();
    t_select();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule